// File: doc/BRIEF.md
# Switch-Selected Decade Frequency Divider

This block runs directly on a disciplined 10 MHz reference clock. The undivided reference is forwarded to its own output at all times. A second output carries a symmetric square wave whose rate is set by a 4-bit position code from a ten-way selector. The selector offers, in order, Off, 5 MHz, 2.5 MHz, 1 MHz, 100 kHz, 10 kHz, 1 kHz, 100 Hz, 10 Hz and 1 Hz. All ratios are even, so the high and low phases are always equal.

The position code is synchronised and debounced before it is used. When a new position is accepted, the divided output is forced low for a pause of a whole number of 10 kHz comparison periods (25 periods, 2.5 ms, by default). After the pause the new ratio starts from a cleared counter with the output low, so no runt pulse appears at a switch-over. In the Off position the divided output stays static, so it cannot disturb the reference output.

The block has no data stream. The position code and both clock outputs are plain level signals with no handshake.

Top module: `decade_freq_divider`

## Requirements
- R1: `ref_out` follows `clk` at all times, including during reset and pauses.
- R2: Position codes 1 to 9 give half-periods of 1, 2, 5, 5·D, 5·D², 5·D³, 5·D⁴, 5·D⁵ and 5·D⁶ clock cycles, where D is the `DECADE` parameter (default 10, which gives 5 MHz down to 1 Hz from 10 MHz). The high phase and the low phase each last exactly that many cycles.
- R3: Codes 10 to 15 select the same Off position as code 0.
- R4: While the Off position is in effect, `div_out` is held low.
- R5: `sel_code` passes two synchroniser flops. A new position is accepted only after the code has stayed unchanged for more than `DEB_CYCLES` clocks. A code held for `DEB_CYCLES` clocks or fewer is ignored.
- R6: Each accepted position change forces `div_out` low for a pause of exactly `CMP_CYCLES`·`CMP_PERIODS` clocks.
- R7: After the pause, the new ratio starts from a cleared count with the output low. When a code is applied just after a clock edge, the first rising edge of `div_out` follows the 4+`DEB_CYCLES`+pause+half-period'th rising clock edge.
- R8: After reset, the position is Off, no pause is running and `div_out` is low.
- R9: Re-selecting the position already in effect, either with the same code or with an alias of Off, causes no pause and leaves the waveform undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Disciplined reference clock (nominally 10 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_code | input | 4 | Selector position code, asynchronous to nothing but may bounce |
| ref_out | output | 1 | Undivided copy of the reference clock |
| div_out | output | 1 | Divided square wave, low when Off or pausing |

## Verification
The assertions check on every cycle that the accepted position stays in range, that an accepted change is always a new value and always starts a pause, and that the output is low throughout every pause and every Off period. They also check that a divider restarts from a cleared count and that the counter never passes its half-period. Only the bench scenarios can show the exact end-to-end latency, the measured high and low widths for each position, and that a short glitch or a re-selection of the current position leaves the running waveform untouched.

// File: rtl/decdiv_pkg.sv
`timescale 1ns/1ps
package decdiv_pkg;
  localparam int unsigned NUM_POS = 10;
  localparam int unsigned SEL_W   = 4;

  // Half-period in clock cycles for a selector position; 0 means Off.
  function automatic int unsigned half_count(int unsigned pos, int unsigned decade);
    int unsigned v;
    if (pos == 0 || pos >= NUM_POS) return 0;
    if (pos == 1) return 1;
    if (pos == 2) return 2;
    v = 5;
    for (int unsigned i = 3; i < NUM_POS; i++) begin
      if (i < pos) v = v * decade;
    end
    return v;
  endfunction
endpackage

// File: rtl/sel_debounce.sv
`timescale 1ns/1ps
module sel_debounce
  import decdiv_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_in,
  output logic [SEL_W-1:0] pos_o,
  output logic             chg_o
);
  localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [SEL_W-1:0] sync1, sync2, cand, acc;
  logic [SEL_W-1:0] norm;
  logic [CNT_W-1:0] stable_cnt;
  logic             chg;

  // Codes beyond the last position alias to Off.
  always_comb norm = (sync2 >= SEL_W'(NUM_POS)) ? '0 : sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= '0;
      sync2      <= '0;
      cand       <= '0;
      acc        <= '0;
      stable_cnt <= '0;
      chg        <= 1'b0;
    end else begin
      sync1 <= code_in;
      sync2 <= sync1;
      chg   <= 1'b0;
      if (norm != cand) begin
        cand       <= norm;
        stable_cnt <= '0;
      end else if (stable_cnt == CNT_LAST) begin
        if (cand != acc) begin
          acc <= cand;
          chg <= 1'b1;
        end
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end

  assign pos_o = acc;
  assign chg_o = chg;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc < SEL_W'(NUM_POS)); // R3
  AST_CHG_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> acc != $past(acc)); // R9
endmodule

// File: rtl/pause_timer.sv
`timescale 1ns/1ps
module pause_timer #(
  parameter int unsigned PAUSE_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(PAUSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAUSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt == CNT_LAST) busy_q <= 1'b0;
      else                 cnt    <= cnt + 1'b1;
    end
  end

  assign busy = busy_q;

  AST_PAUSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt <= CNT_LAST); // R6
endmodule

// File: rtl/square_divider.sv
`timescale 1ns/1ps
module square_divider #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             q
);
  logic [CNT_W-1:0] cnt;
  logic             q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q_r <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      q_r <= 1'b0;
    end else if (cnt == half_m1) begin
      cnt <= '0;
      q_r <= ~q_r;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign q = q_r;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_m1); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !q_r); // R4
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!q_r && cnt == '0)); // R7
endmodule

// File: rtl/decade_freq_divider.sv
`timescale 1ns/1ps
module decade_freq_divider
  import decdiv_pkg::*;
#(
  parameter int unsigned DECADE      = 10,
  parameter int unsigned CMP_CYCLES  = 1000,
  parameter int unsigned CMP_PERIODS = 25,
  parameter int unsigned DEB_CYCLES  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  output logic             ref_out,
  output logic             div_out
);
  localparam int unsigned PAUSE_CYCLES = CMP_CYCLES * CMP_PERIODS;
  localparam int unsigned MAX_HALF     = half_count(NUM_POS - 1, DECADE);
  localparam int unsigned HALF_W       = $clog2(MAX_HALF + 1);
  localparam int unsigned TAB_N        = 1 << SEL_W;

  logic [SEL_W-1:0]  pos;
  logic              chg;
  logic              pausing;
  logic              run;
  logic [HALF_W-1:0] half_tab [TAB_N];
  logic [HALF_W-1:0] half_m1;

  assign ref_out = clk;

  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    assign half_tab[g] = HALF_W'(half_count(g, DECADE));
  end

  sel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (sel_code),
    .pos_o   (pos),
    .chg_o   (chg)
  );

  pause_timer #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_pause (
    .clk   (clk),
    .rst_n (rst_n),
    .start (chg),
    .busy  (pausing)
  );

  assign half_m1 = half_tab[pos] - 1'b1;
  assign run     = !pausing && !chg && (pos != '0);

  square_divider #(.CNT_W(HALF_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half_m1 (half_m1),
    .q       (div_out)
  );

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |=> !div_out); // R4
  AST_PAUSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pausing |-> !div_out); // R6
  AST_CHG_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> pausing); // R6
endmodule

// File: tb/decade_freq_divider_tb.sv
`timescale 1ns/1ps
module decade_freq_divider_tb;
  localparam int unsigned DECADE = 2;
  localparam int unsigned CMPC   = 20;
  localparam int unsigned CMPP   = 5;
  localparam int unsigned DEB    = 4;
  localparam int unsigned PAUSE  = CMPC * CMPP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel_code = 4'd0;
  logic       ref_out, div_out;
  int         n_checks = 0;
  int         n_fail = 0;
  int         cur_pos = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  decade_freq_divider #(.DECADE(DECADE), .CMP_CYCLES(CMPC), .CMP_PERIODS(CMPP),
                        .DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .ref_out(ref_out), .div_out(div_out)
  );

  function automatic int exp_half(int p);
    int v;
    if (p == 0 || p > 9) return 0;
    if (p == 1) return 1;
    if (p == 2) return 2;
    v = 5;
    for (int i = 3; i < p; i++) v = v * DECADE;
    return v;
  endfunction

  function automatic int norm_pos(int code);
    return (code > 9) ? 0 : code;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R2: measure one full high and low phase
  task automatic measure_wave(int h, string req);
    int hi = 0, lo = 0, guard = 0;
    while (div_out !== 1'b0 && guard < 4000) begin tick(); guard++; end
    while (div_out !== 1'b1 && guard < 4000) begin tick(); guard++; end
    while (div_out === 1'b1 && guard < 4000) begin tick(); hi++; guard++; end
    while (div_out === 1'b0 && guard < 4000) begin tick(); lo++; guard++; end
    check(hi == h, req, hi, h);
    check(lo == h, req, lo, h);
  endtask

  // R9/R5: no pause over a window longer than the pause path
  task automatic no_change_window(int p, string req);
    int h = exp_half(p);
    int run_lo = 0, max_lo = 0, highs = 0;
    for (int i = 0; i < int'(4 + DEB + PAUSE + 20); i++) begin
      tick();
      if (div_out === 1'b1) begin highs++; run_lo = 0; end
      else begin run_lo++; if (run_lo > max_lo) max_lo = run_lo; end
    end
    if (p == 0) check(highs == 0, req, highs, 0);
    else check(max_lo <= h, req, max_lo, h);
  endtask

  task automatic apply(int code);
    int np = norm_pos(code);
    int h = exp_half(np);
    int first = 4 + DEB;
    int rise = 4 + DEB + PAUSE + h;
    int bad = 0;
    @(negedge clk);
    sel_code = 4'(code);
    if (np == cur_pos) begin
      no_change_window(np, "R9 reselect");
      if (np != 0) measure_wave(h, "R2 width after reselect");
      return;
    end
    for (int n = 1; n <= rise + (np == 0 ? 40 : 0); n++) begin
      tick();
      if (n >= first && (np == 0 || n < rise) && div_out !== 1'b0) bad++;
      if (np != 0 && n == rise)
        check(div_out === 1'b1, "R7 first rise after pause", int'(div_out), 1);
    end
    check(bad == 0, np == 0 ? "R4 off low" : "R6 pause low", bad, 0);
    cur_pos = np;
    if (np != 0) measure_wave(h, "R2 half-period width");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // R1: reference passthrough on both clock levels
  always @(negedge clk) if (!done) begin
    #1 check(ref_out === clk, "R1 ref low", int'(ref_out), int'(clk));
  end
  always @(posedge clk) if (!done) begin
    #1 check(ref_out === clk, "R1 ref high", int'(ref_out), int'(clk));
  end

  initial begin
    #800000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    done = 1'b1;
    finish_run();
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd2024));
    repeat (3) tick();
    check(div_out === 1'b0, "R8 reset low", int'(div_out), 0);
    rst_n = 1'b1;
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (div_out !== 1'b0) hi_cnt++; end
    check(hi_cnt == 0, "R8 off after reset", hi_cnt, 0);

    apply(15);            // R3 alias of Off, no change
    apply(1);             // fastest
    apply(9);             // slowest
    apply(12);            // R3 alias to Off from running
    apply(3);
    apply(3);             // R9 same code
    apply(4);
    // R5: glitch held exactly DEB cycles is ignored
    @(negedge clk);
    sel_code = 4'd7;
    repeat (DEB) @(negedge clk);
    sel_code = 4'd4;
    no_change_window(4, "R5 short glitch ignored");
    measure_wave(exp_half(4), "R5 width kept");
    apply(0);
    apply(10);            // R9 Off alias reselect
    for (int k = 0; k < 16; k++) begin
      int c = ($urandom % 4 == 0) ? int'($urandom % 16) : int'(1 + $urandom % 9);
      apply(c);
    end
    done = 1'b1;
    finish_run();
  end
endmodule